// File: doc/BRIEF.md
# Configurable Clock Output Router

This block takes three source clocks (a system source, a CPU source and a utility source) plus a reference clock, and turns them into four configurable clock outputs, a dedicated CPU clock output and a buffered reference output. Each configurable output selects one of the four sources and a division ratio. The system source offers an irregular menu that includes odd ratios. The CPU and utility sources offer power-of-two ratios, and the reference passes through undivided. All source clocks are level signals sampled by the block clock `clk`. They must be slower than `clk`, and every divider counts detected rising edges of its source.

Two active-low control pins gate the outputs. The output-enable pin disables every output. Depending on a configuration bit, it can also stop every divider. The suspend pin, when suspend is enabled, applies a source mask and an output mask. A suspended source stops its dividers, and every output fed by that source is disabled regardless of its own mask bit. Each output has an enable flag that models three-state, and a disabled output reads low. A divider that restarts after being stopped holds its output low until one full divided period has elapsed, so no runt pulse appears.

The configuration word `cfg_i` is 41 bits wide:
- bit 0: stop mode.
- bit 1: suspend enable.
- bits 4:2: source mask (bit 2 system, bit 3 CPU, bit 4 utility).
- bits 10:5: output mask (bits 5..8 outputs A..D, bit 9 CPU output, bit 10 reference buffer).
- bits 12:11: CPU output ratio code.
- bits 13+7k .. 19+7k: configuration of output k (k = 0..3 for A..D). The low 5 bits are the ratio code and the top 2 bits are the source select (0 system, 1 CPU, 2 utility, 3 reference).

Top module: `clk_out_router`

## Requirements
- R1: An output selecting the system source (select 0) divides by the ratio its code picks. Codes 0 to 17 map to 1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96 and 104 in that order, and codes 18 to 31 give 104. The output period is exactly that many source periods.
- R2: The CPU output divides the CPU source by 1, 2 or 4 for ratio codes 0, 1 and 2; code 3 also gives 4.
- R3: A configurable output selecting the utility source (select 2) divides by 1, 2, 4 or 8 for codes 0 to 3, and by 8 for larger codes. One selecting the CPU source (select 1) divides by 1, 2 or 4 for codes 0, 1 and 2 or more.
- R4: While the output-enable pin is low, all six enable flags are low from the next `clk` edge on.
- R5: A disabled output reads 0, including during reset.
- R6: When a divider restarts, its counter starts from zero, and its output stays low until a full divided period has passed. This applies on leaving a stop (output-enable low with stop mode 1) and on leaving a source suspend. The first rising edge arrives after N source rising edges.
- R7: With stop mode 0, output-enable low only disables the outputs. The dividers keep counting, so after release the edges keep their original phase.
- R8: While suspend is active (suspend enable 1 and suspend pin low), every output whose mask bit is set is disabled. Every source whose mask bit is set is stopped, and every output derived from it is disabled, regardless of that output's own bit. The enables update at the next `clk` edge.
- R9: With suspend enable 0, the suspend pin has no effect on any enable.
- R10: The reference buffer output, and any configurable output selecting the reference (select 3), follow the reference clock divided by 1 for every ratio code.
- R11: For ratios of 2 or more, the output is high for floor(N/2) source periods of each N-period cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, faster than every source |
| rst | input | 1 | Synchronous active-high reset |
| src_clk_i | input | 3 | Source clocks: [0] system, [1] CPU, [2] utility |
| ref_clk_i | input | 1 | Reference clock |
| cfg_i | input | 41 | Static configuration word (layout above) |
| oe_n_i | input | 1 | Active-low output enable / stop |
| susp_n_i | input | 1 | Active-low suspend |
| clk_out_o | output | 4 | Configurable clock outputs A..D |
| clk_en_o | output | 4 | Enable flags of outputs A..D |
| cpu_clk_o | output | 1 | CPU clock output |
| cpu_en_o | output | 1 | CPU output enable flag |
| ref_buf_o | output | 1 | Buffered reference output |
| ref_en_o | output | 1 | Reference buffer enable flag |

## Verification
The source mask and an output's own mask bit can both act on the same output in the same cycle. The bench provokes this with random suspend masks and random source selections. It judges each enable flag against a model in which either cause disables the output. Output-enable release and divider restart also coincide. After a stop or a suspend is released, the bench checks that the first rising edge of the output lands in the window that a counter restarted from zero predicts, and that the first pulse has full width.

// File: rtl/clk_router_pkg.sv
package clk_router_pkg;

    localparam int NUM_CFG = 4;
    localparam int NUM_SRC = 4;
    localparam int NUM_CH  = NUM_CFG + 2;
    localparam int CH_CPU  = NUM_CFG;
    localparam int CH_REF  = NUM_CFG + 1;
    localparam int CNT_W   = 7;
    localparam int CODE_W  = 5;
    localparam int CPU_CODE_W = 2;

    typedef enum logic [1:0] {
        SRC_SYS  = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_UTIL = 2'd2,
        SRC_REF  = 2'd3
    } src_e;

    typedef struct packed {
        src_e              sel;
        logic [CODE_W-1:0] code;
    } out_cfg_t;

    typedef struct packed {
        out_cfg_t [NUM_CFG-1:0] outs;
        logic [CPU_CODE_W-1:0]  cpu_code;
        logic [NUM_CH-1:0]      out_mask;
        logic [NUM_SRC-2:0]     src_mask;
        logic                   susp_en;
        logic                   oe_stops;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic logic [CNT_W-1:0] sys_ratio(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (code)
            5'd0:    r = CNT_W'(1);
            5'd1:    r = CNT_W'(2);
            5'd2:    r = CNT_W'(3);
            5'd3:    r = CNT_W'(4);
            5'd4:    r = CNT_W'(5);
            5'd5:    r = CNT_W'(6);
            5'd6:    r = CNT_W'(8);
            5'd7:    r = CNT_W'(10);
            5'd8:    r = CNT_W'(12);
            5'd9:    r = CNT_W'(13);
            5'd10:   r = CNT_W'(20);
            5'd11:   r = CNT_W'(24);
            5'd12:   r = CNT_W'(26);
            5'd13:   r = CNT_W'(40);
            5'd14:   r = CNT_W'(48);
            5'd15:   r = CNT_W'(52);
            5'd16:   r = CNT_W'(96);
            default: r = CNT_W'(104);
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] ratio_for(input src_e s, input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] r;
        case (s)
            SRC_SYS:  r = sys_ratio(code);
            SRC_CPU:  r = (code >= CODE_W'(2)) ? CNT_W'(4) : CNT_W'(1) << code;
            SRC_UTIL: r = (code >= CODE_W'(3)) ? CNT_W'(8) : CNT_W'(1) << code;
            default:  r = CNT_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clk_edge_tap.sv
module clk_edge_tap #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div
    import clk_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             lvl,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] ratio,
    output logic             dout
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] half;
    logic             armed;
    logic             q;
    logic             bypass;
    logic             wrap;

    assign bypass = (ratio <= CNT_W'(1));
    assign half   = ratio >> 1;
    // reload on terminal count; >= also recovers a counter left past a new limit
    assign wrap   = rise && (cnt >= ratio - CNT_W'(1));
    assign cnt_nx = wrap ? '0 : cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            armed <= 1'b0;
            q     <= 1'b0;
        end else if (bypass) begin
            cnt <= '0;
            q   <= 1'b0;
            if (fall) armed <= 1'b1;
        end else if (rise) begin
            cnt <= cnt_nx;
            if (wrap) armed <= 1'b1;
            q <= (armed || wrap) && (cnt_nx < half);
        end
    end

    assign dout = bypass ? (lvl && armed && run) : q;
endmodule

// File: rtl/clk_power_ctl.sv
module clk_power_ctl
    import clk_router_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     oe_n,
    input  logic                     susp_n,
    input  logic                     stop_mode,
    input  logic                     susp_en,
    input  logic [NUM_SRC-2:0]       src_mask,
    input  logic [NUM_CH-1:0]        out_mask,
    input  src_e [NUM_CFG-1:0]       sel,
    output logic [NUM_SRC-1:0]       run_src,
    output logic [NUM_CH-1:0]        ch_en
);
    logic                stopped;
    logic                susp_act;
    logic [NUM_SRC-1:0]  run_nx;
    logic [NUM_CH-1:0]   en_nx;

    assign stopped  = stop_mode && !oe_n;
    assign susp_act = susp_en && !susp_n;

    generate
        for (genvar s = 0; s < NUM_SRC - 1; s++) begin : g_run
            assign run_nx[s] = !stopped && !(susp_act && src_mask[s]);
        end
        for (genvar k = 0; k < NUM_CFG; k++) begin : g_en
            assign en_nx[k] = oe_n && !(susp_act && out_mask[k]) && run_nx[sel[k]];
        end
    endgenerate

    assign run_nx[SRC_REF] = !stopped;
    assign en_nx[CH_CPU]   = oe_n && !(susp_act && out_mask[CH_CPU]) && run_nx[SRC_CPU];
    assign en_nx[CH_REF]   = oe_n && !(susp_act && out_mask[CH_REF]) && run_nx[SRC_REF];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_src <= '0;
            ch_en   <= '0;
        end else begin
            run_src <= run_nx;
            ch_en   <= en_nx;
        end
    end
endmodule

// File: rtl/clk_out_router.sv
module clk_out_router
    import clk_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         src_clk_i,
    input  logic               ref_clk_i,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               oe_n_i,
    input  logic               susp_n_i,
    output logic [NUM_CFG-1:0] clk_out_o,
    output logic [NUM_CFG-1:0] clk_en_o,
    output logic               cpu_clk_o,
    output logic               cpu_en_o,
    output logic               ref_buf_o,
    output logic               ref_en_o
);
    cfg_t                 cfg;
    logic [NUM_SRC-1:0]   src_lvl;
    logic [NUM_SRC-1:0]   src_rise;
    logic [NUM_SRC-1:0]   src_fall;
    logic [NUM_SRC-1:0]   run_src;
    logic [NUM_CH-1:0]    ch_en;
    logic [NUM_CH-1:0]    ch_div;
    src_e [NUM_CFG-1:0]   cfg_sel;
    src_e                 ch_src   [NUM_CH];
    logic [CNT_W-1:0]     ch_ratio [NUM_CH];

    assign cfg     = cfg_t'(cfg_i);
    assign src_lvl = {ref_clk_i, src_clk_i};

    always_comb begin
        for (int k = 0; k < NUM_CFG; k++) begin
            cfg_sel[k]  = cfg.outs[k].sel;
            ch_src[k]   = cfg.outs[k].sel;
            ch_ratio[k] = ratio_for(cfg.outs[k].sel, cfg.outs[k].code);
        end
        ch_src[CH_CPU]   = SRC_CPU;
        ch_ratio[CH_CPU] = ratio_for(SRC_CPU, CODE_W'(cfg.cpu_code));
        ch_src[CH_REF]   = SRC_REF;
        ch_ratio[CH_REF] = CNT_W'(1);
    end

    clk_edge_tap #(.N(NUM_SRC)) u_tap (
        .clk  (clk),
        .rst  (rst),
        .lvl  (src_lvl),
        .rise (src_rise),
        .fall (src_fall)
    );

    clk_power_ctl u_pwr (
        .clk       (clk),
        .rst       (rst),
        .oe_n      (oe_n_i),
        .susp_n    (susp_n_i),
        .stop_mode (cfg.oe_stops),
        .susp_en   (cfg.susp_en),
        .src_mask  (cfg.src_mask),
        .out_mask  (cfg.out_mask),
        .sel       (cfg_sel),
        .run_src   (run_src),
        .ch_en     (ch_en)
    );

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            clk_ratio_div u_div (
                .clk   (clk),
                .rst   (rst),
                .run   (run_src[ch_src[k]]),
                .lvl   (src_lvl[ch_src[k]]),
                .rise  (src_rise[ch_src[k]]),
                .fall  (src_fall[ch_src[k]]),
                .ratio (ch_ratio[k]),
                .dout  (ch_div[k])
            );
        end
    endgenerate

    assign clk_out_o = ch_div[NUM_CFG-1:0] & ch_en[NUM_CFG-1:0];
    assign clk_en_o  = ch_en[NUM_CFG-1:0];
    assign cpu_clk_o = ch_div[CH_CPU] && ch_en[CH_CPU];
    assign cpu_en_o  = ch_en[CH_CPU];
    assign ref_buf_o = ch_div[CH_REF] && ch_en[CH_REF];
    assign ref_en_o  = ch_en[CH_REF];
endmodule

// File: rtl/clk_out_router_chk.sv
module clk_out_router_chk
    import clk_router_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               oe_n_i,
    input logic               susp_n_i,
    input logic               stop_mode,
    input logic               susp_en,
    input logic               cpu_src_masked,
    input logic [NUM_CFG-1:0] clk_out_o,
    input logic [NUM_CFG-1:0] clk_en_o,
    input logic               cpu_clk_o,
    input logic               cpu_en_o,
    input logic               ref_buf_o,
    input logic               ref_en_o
);
    // R5
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((clk_out_o & ~clk_en_o) == '0) && (cpu_en_o || !cpu_clk_o) && (ref_en_o || !ref_buf_o));

    // R4
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n_i |=> (clk_en_o == '0) && !cpu_en_o && !ref_en_o);

    // R8
    susp_src_chk: assert property (@(posedge clk) disable iff (rst)
        (susp_en && !susp_n_i && cpu_src_masked) |=> !cpu_en_o);

    // R9
    susp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n_i && !susp_en) |=> (&clk_en_o) && cpu_en_o && ref_en_o);

    // R6
    restart_low_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && $rose(oe_n_i)) |=> (clk_out_o == '0) && !cpu_clk_o && !ref_buf_o);
endmodule

bind clk_out_router clk_out_router_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .oe_n_i         (oe_n_i),
    .susp_n_i       (susp_n_i),
    .stop_mode      (cfg.oe_stops),
    .susp_en        (cfg.susp_en),
    .cpu_src_masked (cfg.src_mask[1]),
    .clk_out_o      (clk_out_o),
    .clk_en_o       (clk_en_o),
    .cpu_clk_o      (cpu_clk_o),
    .cpu_en_o       (cpu_en_o),
    .ref_buf_o      (ref_buf_o),
    .ref_en_o       (ref_en_o)
);

// File: tb/tb_clk_out_router.sv
`timescale 1ns/1ps
module tb_clk_out_router;
    import clk_router_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] src_clk = '0;
    logic ref_clk = 1'b0;
    cfg_t cfg = '0;
    logic oe_n = 1'b1;
    logic susp_n = 1'b1;
    logic [NUM_CFG-1:0] clk_out, clk_en;
    logic cpu_clk, cpu_en, ref_buf, ref_en;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct { string tag; int ch; int period; } item_t;
    item_t sbq[$];

    clk_out_router dut (
        .clk(clk), .rst(rst), .src_clk_i(src_clk), .ref_clk_i(ref_clk),
        .cfg_i(cfg), .oe_n_i(oe_n), .susp_n_i(susp_n),
        .clk_out_o(clk_out), .clk_en_o(clk_en), .cpu_clk_o(cpu_clk),
        .cpu_en_o(cpu_en), .ref_buf_o(ref_buf), .ref_en_o(ref_en));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // sources: system half period 1 clk, CPU 2, utility 3, reference 2
    int ph = 0;
    always @(posedge clk) begin
        #2;
        ph = ph + 1;
        src_clk[0] = ~src_clk[0];
        if (ph % 2 == 0) src_clk[1] = ~src_clk[1];
        if (ph % 3 == 0) src_clk[2] = ~src_clk[2];
        if (ph % 2 == 0) ref_clk = ~ref_clk;
    end

    function automatic logic ch_bit(input int ch);
        if (ch < NUM_CFG) return clk_out[ch];
        if (ch == CH_CPU) return cpu_clk;
        return ref_buf;
    endfunction

    function automatic logic [NUM_CH-1:0] en_vec();
        return {ref_en, cpu_en, clk_en};
    endfunction

    function automatic logic [NUM_CH-1:0] out_vec();
        return {ref_buf, cpu_clk, clk_out};
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_rise(input int ch, output int t);
        logic p;
        p = ch_bit(ch);
        forever begin
            @(negedge clk);
            if (ch_bit(ch) && !p) break;
            p = ch_bit(ch);
        end
        t = cyc;
    endtask

    task automatic wait_fall(input int ch, output int t);
        logic p;
        p = ch_bit(ch);
        forever begin
            @(negedge clk);
            if (!ch_bit(ch) && p) break;
            p = ch_bit(ch);
        end
        t = cyc;
    endtask

    // monitor: measures the interval between two later rising edges
    initial begin
        forever begin
            item_t it;
            int t1, t2, t3;
            while (sbq.size() == 0) @(negedge clk);
            it = sbq[0];
            wait_rise(it.ch, t1);
            wait_rise(it.ch, t2);
            wait_rise(it.ch, t3);
            check(it.tag, t3 - t2, it.period);
            void'(sbq.pop_front());
        end
    end

    task automatic apply_cfg(input cfg_t c);
        @(negedge clk);
        cfg = c;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_period(input string tag, input cfg_t c, input int ch, input int p);
        item_t it;
        apply_cfg(c);
        it.tag = tag; it.ch = ch; it.period = p;
        sbq.push_back(it);
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // restart after stop (use_susp=0) or suspend (use_susp=1); output A, ratio 5
    task automatic restart_case(input bit use_susp);
        cfg_t c;
        int n, t, tf;
        c = '0;
        c.outs[0].sel = SRC_SYS; c.outs[0].code = 5'd4;
        if (use_susp) begin c.susp_en = 1'b1; c.src_mask = 3'b001; end
        else c.oe_stops = 1'b1;
        apply_cfg(c);
        repeat (20) @(negedge clk);
        if (use_susp) susp_n = 1'b0; else oe_n = 1'b0;
        repeat (7) @(negedge clk);
        check(use_susp ? "R8 suspended A off" : "R4 stop enables", int'(en_vec()), use_susp ? 6'b110000 : 0);
        check("R5 held low", int'(out_vec()), 0);
        if (use_susp) susp_n = 1'b1; else oe_n = 1'b1;
        n = cyc;
        wait_rise(0, t);
        check("R6 first edge after restart", int'(t - n >= 10 && t - n <= 11), 1);
        wait_fall(0, tf);
        check("R6 R11 first pulse width", tf - t, 4);
    endtask

    int menu[18] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 13, 20, 24, 26, 40, 48, 52, 96, 104};

    initial begin
        cfg_t c;
        int tr, tf, t;
        repeat (3) @(negedge clk);
        check("R5 reset outputs", int'(out_vec()), 0);
        check("R5 reset enables", int'(en_vec()), 0);
        rst = 1'b0;

        // R1: system menu
        for (int i = 0; i < 18; i++) begin
            c = '0; c.outs[0].sel = SRC_SYS; c.outs[0].code = CODE_W'(i);
            expect_period($sformatf("R1 code %0d", i), c, 0, 2 * menu[i]);
        end
        c = '0; c.outs[0].sel = SRC_SYS; c.outs[0].code = 5'd25;
        expect_period("R1 code 25", c, 0, 208);

        // R11 duty for ratio 13 and 2
        c = '0; c.outs[0].code = 5'd9; apply_cfg(c);
        repeat (60) @(negedge clk);
        wait_rise(0, tr); wait_fall(0, tf);
        check("R11 high width ratio 13", tf - tr, 12);
        c = '0; c.outs[0].code = 5'd1; apply_cfg(c);
        repeat (10) @(negedge clk);
        wait_rise(0, tr); wait_fall(0, tf);
        check("R11 high width ratio 2", tf - tr, 2);

        // R2: CPU output
        for (int i = 0; i < 4; i++) begin
            c = '0; c.cpu_code = 2'(i);
            expect_period($sformatf("R2 cpu code %0d", i), c, CH_CPU, 4 * ((i >= 2) ? 4 : (1 << i)));
        end

        // R3: utility and CPU sources on configurable outputs
        for (int i = 0; i < 5; i++) begin
            c = '0; c.outs[1].sel = SRC_UTIL; c.outs[1].code = CODE_W'(i);
            expect_period($sformatf("R3 util code %0d", i), c, 1, 6 * ((i >= 3) ? 8 : (1 << i)));
        end
        c = '0; c.outs[3].sel = SRC_CPU; c.outs[3].code = 5'd1;
        expect_period("R3 cpu on D code 1", c, 3, 8);
        c = '0; c.outs[3].sel = SRC_CPU; c.outs[3].code = 5'd9;
        expect_period("R3 cpu on D code 9", c, 3, 16);

        // R10: reference buffer and reference selection
        c = '0; c.outs[2].sel = SRC_REF; c.outs[2].code = 5'd7;
        expect_period("R10 ref on C", c, 2, 4);
        expect_period("R10 ref buffer", c, CH_REF, 4);

        // R7: OE-only mode keeps phase
        c = '0; c.outs[0].code = 5'd4; apply_cfg(c);
        repeat (20) @(negedge clk);
        wait_rise(0, tr); wait_fall(0, tf);
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 oe low enables", int'(en_vec()), 0);
        check("R5 oe low outputs", int'(out_vec()), 0);
        repeat (27) @(negedge clk);
        oe_n = 1'b1;
        wait_rise(0, t);
        check("R7 phase kept", (t - tr) % 10, 0);

        // R6: restart after stop and after suspend
        restart_case(1'b0);
        restart_case(1'b1);

        // R8: random masks while suspended
        for (int it = 0; it < 16; it++) begin
            logic [NUM_CH-1:0] exp_en;
            int s;
            c = '0;
            c.susp_en  = 1'b1;
            c.src_mask = 3'($urandom_range(0, 7));
            c.out_mask = 6'($urandom_range(0, 63));
            for (int k = 0; k < NUM_CFG; k++) c.outs[k].sel = src_e'($urandom_range(0, 3));
            apply_cfg(c);
            susp_n = 1'b0;
            repeat (3) @(negedge clk);
            for (int k = 0; k < NUM_CH; k++) begin
                s = (k < NUM_CFG) ? int'(c.outs[k].sel) : ((k == CH_CPU) ? 1 : 3);
                exp_en[k] = !(c.out_mask[k] || (s < 3 && c.src_mask[s]));
            end
            check($sformatf("R8 random mask %0d", it), int'(en_vec()), int'(exp_en));
            repeat (6) @(negedge clk);
            check("R5 masked outputs low", int'(out_vec() & ~en_vec()), 0);
            susp_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        // R9: suspend disabled in configuration
        c = '0; c.susp_en = 1'b0; c.src_mask = 3'b111; c.out_mask = 6'b111111;
        apply_cfg(c);
        susp_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 suspend ignored", int'(en_vec()), 63);
        susp_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule